// File: doc/BRIEF.md
# UART Interrupt Cause and Mask Controller

This block collects every interrupt source of a serial port into one sticky cause register. A masked OR of that register drives a single level interrupt line. Five live FIFO condition flags are sampled on every clock. Any flag seen high sets its cause bit, and the bit stays set after the flag drops. Five one-cycle event pulses set the remaining cause bits: overrun, framing error, parity error, receive timeout and modem-line change.

Software acts on the block through a word-wide register port addressed by byte offset. The mask cannot be written directly. Bits are set through a write-one-to-set address and cleared through a write-one-to-clear address, so separate drivers can change their own bits without a read-modify-write. The cause register is cleared by writing ones to the bits to drop. A source that is still active on the same clock keeps its bit set.

Reads return the mask, the cause register or the raw live flags one clock after the read strobe. Baud timing, FIFOs and the serial shifters sit outside the block.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Live flag inputs bit 0 (receive level reached), bit 1 (receive empty), bit 2 (receive full), bit 3 (transmit empty) and bit 4 (transmit full) set the cause bit of the same index on any clock where they are high, and that cause bit stays set after the flag returns low.
- R2: A one-cycle pulse on the overrun, framing, parity, timeout or modem-change input sets cause bit 5, 6, 7, 8 or 9 respectively.
- R3: A write to offset 0x08 ORs write-data bits 9..0 into the mask; write-data bits above bit 9 have no effect.
- R4: A write to offset 0x0C clears every mask bit whose write-data bit is one and leaves the other mask bits unchanged.
- R5: A write to the mask's read address 0x10 leaves the mask unchanged.
- R6: A write to offset 0x14 clears every cause bit whose write-data bit is one; writing zero bits changes nothing.
- R7: While reset is high the mask, the cause register, the interrupt output and the read data are all zero.
- R8: The interrupt output is a register that is high exactly when (mask AND cause) is nonzero. It reflects a write or event from cycle k in cycle k+1.
- R9: When a cause bit is cleared by a write in the same cycle that its live flag or event pulse is high, the bit stays set.
- R10: A read strobe in cycle k returns, in cycle k+1, the mask for offset 0x10, the cause for 0x14, the live flags for 0x2C and zero for every other offset, zero-extended to the bus width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (8) | Byte offset of the access |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| live_stat | input | 5 | Live FIFO condition flags |
| evt_overrun | input | 1 | Receive overrun pulse |
| evt_frame | input | 1 | Framing error pulse |
| evt_parity | input | 1 | Parity error pulse |
| evt_timeout | input | 1 | Receive timeout pulse |
| evt_modem | input | 1 | Modem-line change pulse |
| irq | output | 1 | Level interrupt request |

## Verification
The bench uses the default parameters: a 32-bit data bus and an 8-bit byte offset. With the 32-bit bus, enable writes can carry ones above bit 9, so the bench can show that those bits are dropped. With the 8-bit offset, the live-flag offset 0x2C and unmapped offsets such as 0x30 can be addressed, so the zero read-back can be shown. The run includes a clear written in the same cycle as a new framing pulse and as a held-high live flag. It also follows the interrupt line as a single mask or cause bit is moved.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NUM_LIVE = 5;
  localparam int NUM_EVT  = 5;
  localparam int NUM_SRC  = NUM_LIVE + NUM_EVT;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_EN,
    SEL_DIS,
    SEL_MASK,
    SEL_CAUSE,
    SEL_LIVE
  } reg_sel_e;
endpackage

// File: rtl/uart_irq_decode.sv
module uart_irq_decode
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int OFS_EN    = 'h08,
  parameter int OFS_DIS   = 'h0C,
  parameter int OFS_MASK  = 'h10,
  parameter int OFS_CAUSE = 'h14,
  parameter int OFS_LIVE  = 'h2C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output reg_sel_e          sel,
  output logic              en_we,
  output logic              dis_we,
  output logic              clr_we
);
  always_comb begin
    sel = SEL_NONE;
    if (bus_addr == ADDR_W'(OFS_EN))         sel = SEL_EN;
    else if (bus_addr == ADDR_W'(OFS_DIS))   sel = SEL_DIS;
    else if (bus_addr == ADDR_W'(OFS_MASK))  sel = SEL_MASK;
    else if (bus_addr == ADDR_W'(OFS_CAUSE)) sel = SEL_CAUSE;
    else if (bus_addr == ADDR_W'(OFS_LIVE))  sel = SEL_LIVE;
  end

  // SEL_MASK and SEL_LIVE produce no strobe: those offsets are read-only
  assign en_we  = bus_wr && (sel == SEL_EN);
  assign dis_we = bus_wr && (sel == SEL_DIS);
  assign clr_we = bus_wr && (sel == SEL_CAUSE);

  // R3, R4, R6: at most one register is modified per access
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({en_we, dis_we, clr_we}));
endmodule

// File: rtl/uart_irq_mask.sv
module uart_irq_mask #(
  parameter int NUM_SRC = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set_we,
  input  logic               clr_we,
  input  logic [NUM_SRC-1:0] wval,
  output logic [NUM_SRC-1:0] mask_q,
  output logic [NUM_SRC-1:0] mask_d
);
  always_comb begin
    mask_d = mask_q;
    if (set_we) mask_d = mask_q | wval;
    if (clr_we) mask_d = mask_d & ~wval;
  end

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= mask_d;
  end

  // R5: without a set or clear strobe the mask holds its value
  a_r5_mask_only_via_strobes: assert property (@(posedge clk) disable iff (rst)
    !(set_we || clr_we) |=> $stable(mask_q));

  // R4: bits named in a clear write are low afterwards
  a_r4_clear_takes_effect: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((mask_q & $past(wval)) == '0));
endmodule

// File: rtl/uart_irq_cause.sv
module uart_irq_cause #(
  parameter int NUM_LIVE = 5,
  parameter int NUM_EVT  = 5,
  localparam int NUM_SRC = NUM_LIVE + NUM_EVT
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_LIVE-1:0] live,
  input  logic [NUM_EVT-1:0]  evt,
  input  logic                clr_we,
  input  logic [NUM_SRC-1:0]  wval,
  output logic [NUM_SRC-1:0]  cause_q,
  output logic [NUM_SRC-1:0]  cause_d
);
  logic [NUM_SRC-1:0] set_vec;
  logic [NUM_SRC-1:0] clr_vec;

  assign set_vec = {evt, live};
  assign clr_vec = clr_we ? wval : '0;

  for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
    // a pending source overrides a clear aimed at the same bit
    assign cause_d[b] = set_vec[b] | (cause_q[b] & ~clr_vec[b]);

    always_ff @(posedge clk) begin
      if (rst) cause_q[b] <= 1'b0;
      else     cause_q[b] <= cause_d[b];
    end
  end

  // R9 / R1 / R2: every active source leaves its bit set after the edge
  a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
    (|set_vec) |=> ((cause_q & $past(set_vec)) == $past(set_vec)));

  // R6: bits only fall through a clear write
  a_r6_no_drop_without_write: assert property (@(posedge clk) disable iff (rst)
    !clr_we |=> ((cause_q & $past(cause_q)) == $past(cause_q)));
endmodule

// File: rtl/uart_irq_rdmux.sv
module uart_irq_rdmux
  import uart_irq_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_LIVE = 5,
  parameter int NUM_SRC  = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_en,
  input  reg_sel_e            sel,
  input  logic [NUM_SRC-1:0]  mask_q,
  input  logic [NUM_SRC-1:0]  cause_q,
  input  logic [NUM_LIVE-1:0] live,
  output logic [DATA_W-1:0]   rdata
);
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    unique case (sel)
      SEL_MASK:  rd_mux = DATA_W'(mask_q);
      SEL_CAUSE: rd_mux = DATA_W'(cause_q);
      SEL_LIVE:  rd_mux = DATA_W'(live);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // R10: unmapped or write-only offsets read back as zero
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (sel == SEL_NONE || sel == SEL_EN || sel == SEL_DIS)) |=> (rdata == '0));
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int OFS_EN    = 'h08,
  parameter int OFS_DIS   = 'h0C,
  parameter int OFS_MASK  = 'h10,
  parameter int OFS_CAUSE = 'h14,
  parameter int OFS_LIVE  = 'h2C
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_LIVE-1:0] live_stat,
  input  logic                evt_overrun,
  input  logic                evt_frame,
  input  logic                evt_parity,
  input  logic                evt_timeout,
  input  logic                evt_modem,
  output logic                irq
);
  reg_sel_e           sel;
  logic               en_we, dis_we, clr_we;
  logic [NUM_SRC-1:0] wval;
  logic [NUM_SRC-1:0] mask_q, mask_d;
  logic [NUM_SRC-1:0] cause_q, cause_d;
  logic [NUM_EVT-1:0] evt_vec;
  logic               irq_q;
  logic               unused_wdata_hi;

  assign wval            = bus_wdata[NUM_SRC-1:0];
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_SRC];
  assign evt_vec = {evt_modem, evt_timeout, evt_parity, evt_frame, evt_overrun};

  uart_irq_decode #(
    .ADDR_W(ADDR_W), .OFS_EN(OFS_EN), .OFS_DIS(OFS_DIS),
    .OFS_MASK(OFS_MASK), .OFS_CAUSE(OFS_CAUSE), .OFS_LIVE(OFS_LIVE)
  ) u_decode (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .sel(sel), .en_we(en_we), .dis_we(dis_we), .clr_we(clr_we)
  );

  uart_irq_mask #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk(clk), .rst(rst), .set_we(en_we), .clr_we(dis_we),
    .wval(wval), .mask_q(mask_q), .mask_d(mask_d)
  );

  uart_irq_cause #(.NUM_LIVE(NUM_LIVE), .NUM_EVT(NUM_EVT)) u_cause (
    .clk(clk), .rst(rst), .live(live_stat), .evt(evt_vec),
    .clr_we(clr_we), .wval(wval), .cause_q(cause_q), .cause_d(cause_d)
  );

  uart_irq_rdmux #(.DATA_W(DATA_W), .NUM_LIVE(NUM_LIVE), .NUM_SRC(NUM_SRC)) u_rdmux (
    .clk(clk), .rst(rst), .rd_en(bus_rd), .sel(sel),
    .mask_q(mask_q), .cause_q(cause_q), .live(live_stat), .rdata(bus_rdata)
  );

  // irq is computed from next-state values so it moves on the same edge as the registers
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(mask_d & cause_d);
  end
  assign irq = irq_q;

  // R8: interrupt line agrees with the stored mask and cause
  a_r8_irq_tracks_regs: assert property (@(posedge clk) disable iff (rst)
    irq_q == |(mask_q & cause_q));

  // R7: first cycle after reset leaves everything cleared
  a_r7_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask_q == '0 && cause_q == '0 && !irq_q && bus_rdata == '0));
endmodule

// File: tb/uart_irq_ctrl_tb.sv
module uart_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [4:0]  live_stat = '0;
  logic [4:0]  ev = '0;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [9:0] m_mask = '0;
  logic [9:0] m_cause = '0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_d = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .live_stat(live_stat), .evt_overrun(ev[0]), .evt_frame(ev[1]),
    .evt_parity(ev[2]), .evt_timeout(ev[3]), .evt_modem(ev[4]), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  // monitor: pops one expected value per completed read
  always @(posedge clk) rd_d <= bus_rd;
  always @(negedge clk) begin
    if (rd_d && !rst) begin
      if (exp_q.size() == 0) check("R10 unexpected read", bus_rdata, 32'hDEAD);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  function automatic logic [31:0] model_read(input logic [7:0] a, input logic [4:0] lv);
    case (a)
      8'h10:   return {22'd0, m_mask};
      8'h14:   return {22'd0, m_cause};
      8'h2C:   return {27'd0, lv};
      default: return 32'd0;
    endcase
  endfunction

  // driver: one bus cycle, starting and ending at a falling edge
  task automatic step(input logic w, input logic r, input logic [7:0] a,
                      input logic [31:0] d, input logic [4:0] lv,
                      input logic [4:0] evv, input string tag);
    logic [9:0] clr;
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    live_stat = lv; ev = evv;
    if (r) begin
      exp_q.push_back(model_read(a, lv));
      tag_q.push_back(tag);
    end
    if (w && a == 8'h08) m_mask = m_mask | d[9:0];
    if (w && a == 8'h0C) m_mask = m_mask & ~d[9:0];
    clr = (w && a == 8'h14) ? d[9:0] : 10'd0;
    m_cause = (m_cause & ~clr) | {evv, lv};
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; ev = '0; live_stat = '0;
    check({"R8 irq after ", tag}, {31'd0, irq}, {31'd0, |(m_mask & m_cause)});
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    step(1'b0, 1'b1, a, 32'd0, 5'd0, 5'd0, tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    step(1'b1, 1'b0, a, d, 5'd0, 5'd0, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R7 irq in reset", {31'd0, irq}, 32'd0);
    check("R7 rdata in reset", bus_rdata, 32'd0);
    rst = 1'b0;
    rd(8'h10, "R7 mask after reset");
    rd(8'h14, "R7 cause after reset");

    // R1: live flags are sticky
    step(1'b0, 1'b0, 8'h00, 0, 5'b00101, 5'd0, "R1 live pulse");
    step(1'b0, 1'b0, 8'h00, 0, 5'd0, 5'd0, "R1 idle");
    rd(8'h14, "R1 sticky live bits");

    // R2: overrun, parity, modem
    step(1'b0, 1'b0, 8'h00, 0, 5'd0, 5'b10101, "R2 event pulses");
    rd(8'h14, "R2 event bits");

    // R6: write-one-to-clear
    wr(8'h14, 32'h004, "R6 clear bit2");
    rd(8'h14, "R6 cause after clear");
    wr(8'h14, 32'h000, "R6 zero clear");
    rd(8'h14, "R6 cause unchanged");

    // R3: enable with high junk bits
    wr(8'h08, 32'hFFFF_FC00 | 32'h0A0, "R3 enable");
    rd(8'h10, "R3 mask after enable");

    // R4: disable
    wr(8'h0C, 32'h020, "R4 disable bit5");
    rd(8'h10, "R4 mask after disable");

    // R5: direct write ignored
    wr(8'h10, 32'h3FF, "R5 direct mask write");
    rd(8'h10, "R5 mask unchanged");

    // R8: dropping the only enabled pending bit lowers irq
    wr(8'h14, 32'h080, "R8 clear parity");
    check("R8 irq low", {31'd0, irq}, 32'd0);

    // R9: set wins over clear
    step(1'b1, 1'b0, 8'h14, 32'h040, 5'd0, 5'b00010, "R9 frame vs clear");
    rd(8'h14, "R9 frame kept");
    step(1'b1, 1'b0, 8'h14, 32'h001, 5'b00001, 5'd0, "R9 live vs clear");
    rd(8'h14, "R9 live kept");

    // R10: read map
    step(1'b0, 1'b1, 8'h2C, 0, 5'b10010, 5'd0, "R10 live read");
    rd(8'h08, "R10 enable offset reads zero");
    rd(8'h30, "R10 unmapped reads zero");

    // R8: timeout raises irq one cycle after the pulse
    wr(8'h08, 32'h100, "R8 enable timeout");
    step(1'b0, 1'b0, 8'h00, 0, 5'd0, 5'b01000, "R8 timeout pulse");
    check("R8 irq high", {31'd0, irq}, 32'd1);
    wr(8'h0C, 32'h3FF, "R4 disable all");
    check("R8 irq masked off", {31'd0, irq}, 32'd0);
    rd(8'h10, "R4 mask empty");

    repeat (3) @(negedge clk);
    check("R10 all reads returned", exp_q.size(), 32'd0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule